// File: doc/BRIEF.md
# In-Order Retirement Queue

This block sits between instruction decode and the architectural state of an out-of-order core. Decode claims a slot at the tail of a circular queue and is given that slot's index. Functional units finish in any order and write their result, an optional store address and an exception flag back into the slot by index. Architectural state changes only at the head. The oldest slot retires only once it is finished. A finished slot with no exception produces either a register-file write or a store. A finished slot that carries an exception produces a flush request with its saved PC, and the whole queue is emptied at the next clock edge.

Decode can also present a register ID. The queue then reports whether an uncommitted producer of that register exists, whether its value is ready, and the value itself, so the value can be forwarded before it is committed. When several slots target the same register, the youngest one is reported.

Occupancy is tracked by a three-state controller. EMPTY moves to PARTIAL on an allocation, or straight to FULL when the depth is one. PARTIAL moves to FULL when an allocation without a retirement fills the last slot. It moves to EMPTY when a retirement without an allocation frees the last slot, or on a flush. FULL moves to PARTIAL on a retirement, or to EMPTY on a flush. The controller stays in its current state on any other input combination.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty. `alloc_ready` is 1, `alloc_idx` is 0, and `rf_we`, `st_valid`, `flush` and `look_hit` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes the slot shown on `alloc_idx`. Successive accepted allocations get indices that increase by one and wrap from DEPTH-1 to 0.
- R3: While DEPTH slots are occupied, `alloc_ready` is 0 and `alloc_valid` has no effect. An allocation is refused while the queue is full even in a cycle where the head retires.
- R4: A completion (`cmp_valid` with `cmp_idx`) marks its slot finished. Completions may arrive in any order. A finished slot that is younger than an unfinished head waits and does not retire.
- R5: When the head slot is finished, has no exception and is not a store, `rf_we` is 1 in that same cycle, with the slot's destination on `rf_waddr` and its result on `rf_wdata`. At most one slot retires per cycle, and slots retire in allocation order.
- R6: When the finished head slot is a store with no exception, `st_valid` is 1, with the completed address on `st_addr` and the completed value on `st_data`. `rf_we` stays 0.
- R7: When the finished head slot carries an exception, `flush` is 1 and `flush_pc` equals that slot's allocation PC. `rf_we` and `st_valid` are 0. After the next edge every slot is empty and `alloc_idx` is 0. An allocation or completion presented in the flush cycle is discarded.
- R8: A lookup of `look_reg` searches every occupied non-store slot whose destination equals `look_reg`. `look_hit` reports whether any slot matches. The youngest match sets `look_ready` to its finished bit and `look_value` to its result. Store slots never match.
- R9: An allocation and a retirement in the same cycle both take effect and leave the occupancy unchanged.
- R10: A completion whose index names an unoccupied slot is ignored. If that slot is allocated later, it starts out unfinished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_is_store | input | 1 | New slot is a store rather than a register write |
| alloc_dest | input | REG_W | Destination register ID of the new slot |
| alloc_pc | input | ADDR_W | PC saved with the new slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | IDX_W | Index the next accepted allocation receives |
| cmp_valid | input | 1 | A functional unit delivers a result |
| cmp_idx | input | IDX_W | Slot index of the delivered result |
| cmp_value | input | DATA_W | Result, or store data for a store |
| cmp_st_addr | input | ADDR_W | Store address (used by store slots only) |
| cmp_exc | input | 1 | The instruction raised an exception |
| look_reg | input | REG_W | Register ID to search for |
| look_hit | output | 1 | An uncommitted producer of `look_reg` exists |
| look_ready | output | 1 | The youngest producer has finished |
| look_value | output | DATA_W | Result of the youngest producer |
| rf_we | output | 1 | Register-file write from the retiring head |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| st_valid | output | 1 | Store released from the retiring head |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Exception at the head, so the queue is cleared |
| flush_pc | output | ADDR_W | PC of the excepting instruction |

## Verification
Allocation at the tail and retirement at the head can happen in the same edge, and a completion can also land in that edge. The bench builds this case directly: it finishes the head and offers a new allocation in the following cycle. It also produces the case many times with a pseudo-random stream of allocations and completions on a small four-slot configuration. It then checks that the retire port fired, that the tail index advanced by exactly one, and that the occupancy implied by later allocations and refusals matches a count kept arithmetically in the bench. A second overlap is a completion or allocation presented during a flush cycle. The bench checks that neither survives the clear.

// File: rtl/rq_pkg.sv
package rq_pkg;

    // Occupancy condition of the circular queue
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
    import rq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             retire_go,
    input  logic             flush_go,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             alloc_ok,
    output q_state_e         state_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    q_state_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
    logic             alloc_fire;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Output process
    always_comb begin
        alloc_ok   = (state_q != Q_FULL) && !flush_go;
        alloc_fire = alloc_req && alloc_ok;
        head_o     = head_q;
        tail_o     = tail_q;
        state_o    = state_q;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (alloc_fire)
                    state_d = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (flush_go)
                    state_d = Q_EMPTY;
                else if (alloc_fire && !retire_go && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = Q_FULL;
                else if (retire_go && !alloc_fire && cnt_q == CNT_W'(1))
                    state_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (flush_go)
                    state_d = Q_EMPTY;
                else if (retire_go)
                    state_d = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // Pointer and count datapath
    always_comb begin
        if (flush_go) begin
            cnt_d  = '0;
            head_d = '0;
            tail_d = '0;
        end else begin
            cnt_d  = cnt_q + CNT_W'(alloc_fire) - CNT_W'(retire_go);
            head_d = retire_go  ? bump(head_q) : head_q;
            tail_d = alloc_fire ? bump(tail_q) : tail_q;
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            cnt_q   <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    p_fill_to_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !retire_go && cnt_q == CNT_W'(DEPTH - 1)) |=> (state_q == Q_FULL && !alloc_ok));

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (state_q == Q_EMPTY && head_q == '0 && tail_q == '0));

    p_empty_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY) |-> (head_q == tail_q && cnt_q == '0));

    p_pair_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && retire_go) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/rq_slot.sv
module rq_slot #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              take_st,
    input  logic [REG_W-1:0]  take_dest,
    input  logic [ADDR_W-1:0] take_pc,
    input  logic              release_i,
    input  logic              fill,
    input  logic [DATA_W-1:0] fill_val,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_exc,
    output logic              busy_o,
    output logic              done_o,
    output logic              exc_o,
    output logic              st_o,
    output logic [REG_W-1:0]  dest_o,
    output logic [DATA_W-1:0] val_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] pc_o
);

    logic keep_fill;

    always_comb keep_fill = fill && busy_o && !clear && !take && !release_i;

    // Control bits; priority: clear, take, release, fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            exc_o  <= 1'b0;
            st_o   <= 1'b0;
        end else if (clear) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            exc_o  <= 1'b0;
        end else if (take) begin
            busy_o <= 1'b1;
            done_o <= 1'b0;
            exc_o  <= 1'b0;
            st_o   <= take_st;
        end else if (release_i) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else if (keep_fill) begin
            done_o <= 1'b1;
            exc_o  <= fill_exc;
        end
    end

    // Payload fields
    always_ff @(posedge clk) begin
        if (take && !clear) begin
            dest_o <= take_dest;
            pc_o   <= take_pc;
        end
        if (keep_fill) begin
            val_o  <= fill_val;
            addr_o <= fill_addr;
        end
    end

    p_idle_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !take) |=> !done_o);

    p_done_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_o && !release_i && !clear && !take) |=> (busy_o && done_o));

endmodule

// File: rtl/rq_lookup.sv
module rq_lookup #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             head,
    input  logic [DEPTH-1:0]             ent_busy,
    input  logic [DEPTH-1:0]             ent_st,
    input  logic [DEPTH-1:0]             ent_done,
    input  logic [DEPTH-1:0][REG_W-1:0]  ent_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0] ent_val,
    input  logic [REG_W-1:0]             key,
    output logic                         hit_o,
    output logic                         rdy_o,
    output logic [DATA_W-1:0]            val_o
);

    // Walk from oldest to youngest; a later match overrides an earlier one
    always_comb begin
        hit_o = 1'b0;
        rdy_o = 1'b0;
        val_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int               pos;
            logic [IDX_W-1:0] sel;
            pos = int'(head) + k;
            if (pos >= DEPTH)
                pos = pos - DEPTH;
            sel = IDX_W'(pos);
            if (ent_busy[sel] && !ent_st[sel] && ent_dest[sel] == key) begin
                hit_o = 1'b1;
                rdy_o = ent_done[sel];
                val_o = ent_val[sel];
            end
        end
    end

    p_empty_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_busy == '0) |-> !hit_o);

    p_hit_needs_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((ent_busy & ~ent_st) != '0));

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import rq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic [ADDR_W-1:0] alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic [ADDR_W-1:0] cmp_st_addr,
    input  logic              cmp_exc,
    input  logic [REG_W-1:0]  look_reg,
    output logic              look_hit,
    output logic              look_ready,
    output logic [DATA_W-1:0] look_value,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_pc
);

    logic [DEPTH-1:0]             s_busy, s_done, s_exc, s_st;
    logic [DEPTH-1:0][REG_W-1:0]  s_dest;
    logic [DEPTH-1:0][DATA_W-1:0] s_val;
    logic [DEPTH-1:0][ADDR_W-1:0] s_addr, s_pc;

    logic [IDX_W-1:0] head, tail;
    logic             alloc_ok, alloc_fire;
    logic             retire_go, flush_go;
    logic             h_busy, h_done, h_exc, h_st;
    q_state_e         q_state;

    rq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_valid),
        .retire_go (retire_go),
        .flush_go  (flush_go),
        .head_o    (head),
        .tail_o    (tail),
        .alloc_ok  (alloc_ok),
        .state_o   (q_state)
    );

    always_comb alloc_fire = alloc_valid && alloc_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rq_slot #(.REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (flush_go),
            .take      (alloc_fire && tail == IDX_W'(g)),
            .take_st   (alloc_is_store),
            .take_dest (alloc_dest),
            .take_pc   (alloc_pc),
            .release_i (retire_go && head == IDX_W'(g)),
            .fill      (cmp_valid && cmp_idx == IDX_W'(g)),
            .fill_val  (cmp_value),
            .fill_addr (cmp_st_addr),
            .fill_exc  (cmp_exc),
            .busy_o    (s_busy[g]),
            .done_o    (s_done[g]),
            .exc_o     (s_exc[g]),
            .st_o      (s_st[g]),
            .dest_o    (s_dest[g]),
            .val_o     (s_val[g]),
            .addr_o    (s_addr[g]),
            .pc_o      (s_pc[g])
        );
    end

    rq_lookup #(.DEPTH(DEPTH), .IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_look (
        .clk      (clk),
        .rst_n    (rst_n),
        .head     (head),
        .ent_busy (s_busy),
        .ent_st   (s_st),
        .ent_done (s_done),
        .ent_dest (s_dest),
        .ent_val  (s_val),
        .key      (look_reg),
        .hit_o    (look_hit),
        .rdy_o    (look_ready),
        .val_o    (look_value)
    );

    // Head decision and retire outputs
    always_comb begin
        h_busy      = s_busy[head];
        h_done      = s_done[head];
        h_exc       = s_exc[head];
        h_st        = s_st[head];
        retire_go   = h_busy && h_done && !h_exc;
        flush_go    = h_busy && h_done && h_exc;
        alloc_ready = alloc_ok;
        alloc_idx   = tail;
        rf_we       = retire_go && !h_st;
        rf_waddr    = s_dest[head];
        rf_wdata    = s_val[head];
        st_valid    = retire_go && h_st;
        st_addr     = s_addr[head];
        st_data     = s_val[head];
        flush       = flush_go;
        flush_pc    = s_pc[head];
    end

    p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_valid, flush}));

    p_nonempty_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state != Q_EMPTY) |-> h_busy);

    p_full_all_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == Q_FULL) |-> (&s_busy));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_busy == '0));

endmodule

// File: tb/retire_queue_tb.sv
`timescale 1ns/1ps
module retire_queue_tb;

    localparam int D  = 4;
    localparam int RW = 3;
    localparam int DW = 16;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic          alloc_valid, alloc_is_store, alloc_ready;
    logic [RW-1:0] alloc_dest;
    logic [AW-1:0] alloc_pc;
    logic [1:0]    alloc_idx;
    logic          cmp_valid, cmp_exc;
    logic [1:0]    cmp_idx;
    logic [DW-1:0] cmp_value;
    logic [AW-1:0] cmp_st_addr;
    logic [RW-1:0] look_reg;
    logic          look_hit, look_ready;
    logic [DW-1:0] look_value;
    logic          rf_we, st_valid, flush;
    logic [RW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata, st_data;
    logic [AW-1:0] st_addr, flush_pc;

    retire_queue #(.DEPTH(D), .REG_W(RW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_value(cmp_value),
        .cmp_st_addr(cmp_st_addr), .cmp_exc(cmp_exc),
        .look_reg(look_reg), .look_hit(look_hit), .look_ready(look_ready),
        .look_value(look_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .flush(flush), .flush_pc(flush_pc)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Reference occupancy model
    bit          m_v [D];
    bit          m_d [D];
    bit          m_x [D];
    bit          m_s [D];
    logic [RW-1:0] m_dst [D];
    logic [DW-1:0] m_val [D];
    logic [AW-1:0] m_adr [D];
    logic [AW-1:0] m_pc  [D];
    int mh = 0, mt = 0, mc = 0;
    bit e_ar, e_rf, e_st, e_fl;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_valid = 0; alloc_is_store = 0; alloc_dest = '0; alloc_pc = '0;
        cmp_valid = 0; cmp_idx = '0; cmp_value = '0; cmp_st_addr = '0; cmp_exc = 0;
        look_reg = RW'(cyc % 8);
    endtask

    task automatic evaluate();
        bit hv, lh, lr;
        logic [DW-1:0] lv;
        hv   = (mc > 0);
        e_fl = hv && m_d[mh] && m_x[mh];
        e_rf = hv && m_d[mh] && !m_x[mh] && !m_s[mh];
        e_st = hv && m_d[mh] && !m_x[mh] &&  m_s[mh];
        e_ar = (mc < D) && !e_fl;
        chk("R3 alloc_ready", alloc_ready, e_ar);
        chk("R2 alloc_idx", alloc_idx, mt);
        chk("R5 rf_we", rf_we, e_rf);
        if (e_rf) begin
            chk("R5 rf_waddr", rf_waddr, m_dst[mh]);
            chk("R5 rf_wdata", rf_wdata, m_val[mh]);
        end
        chk("R6 st_valid", st_valid, e_st);
        if (e_st) begin
            chk("R6 st_addr", st_addr, m_adr[mh]);
            chk("R6 st_data", st_data, m_val[mh]);
        end
        chk("R7 flush", flush, e_fl);
        if (e_fl) chk("R7 flush_pc", flush_pc, m_pc[mh]);
        lh = 0; lr = 0; lv = '0;
        for (int k = 0; k < mc; k++) begin
            int j;
            j = (mh + k) % D;
            if (!m_s[j] && m_dst[j] == look_reg) begin
                lh = 1; lr = m_d[j]; lv = m_val[j];
            end
        end
        chk("R8 look_hit", look_hit, lh);
        if (lh) chk("R8 look_ready", look_ready, lr);
        if (lh && lr) chk("R8 look_value", look_value, lv);
    endtask

    task automatic model_tick();
        bit ret;
        ret = e_rf || e_st;
        if (e_fl) begin
            for (int j = 0; j < D; j++) m_v[j] = 0;
            mh = 0; mt = 0; mc = 0;
        end else begin
            if (cmp_valid && m_v[cmp_idx] && !(ret && int'(cmp_idx) == mh)) begin
                m_d[cmp_idx] = 1; m_x[cmp_idx] = cmp_exc;
                m_val[cmp_idx] = cmp_value; m_adr[cmp_idx] = cmp_st_addr;
            end
            if (ret) begin
                m_v[mh] = 0; mh = (mh + 1) % D; mc--;
            end
            if (alloc_valid && e_ar) begin
                m_v[mt] = 1; m_d[mt] = 0; m_x[mt] = 0; m_s[mt] = alloc_is_store;
                m_dst[mt] = alloc_dest; m_pc[mt] = alloc_pc;
                mt = (mt + 1) % D; mc++;
            end
        end
    endtask

    task automatic cycle();
        #1;
        evaluate();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        cyc++;
        clear_inputs();
    endtask

    task automatic put(input bit st, input int dst, input int pc);
        alloc_valid = 1; alloc_is_store = st; alloc_dest = RW'(dst); alloc_pc = AW'(pc);
    endtask

    task automatic fin(input int idx, input int val, input int adr, input bit ex);
        cmp_valid = 1; cmp_idx = 2'(idx); cmp_value = DW'(val);
        cmp_st_addr = AW'(adr); cmp_exc = ex;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        int p, t;
        logic [15:0] r;
        for (int j = 0; j < D; j++) begin
            m_v[j] = 0; m_d[j] = 0; m_x[j] = 0; m_s[j] = 0;
        end
        rst_n = 0;
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 alloc_idx", alloc_idx, 0);
        chk("R1 rf_we", rf_we, 0);
        chk("R1 st_valid", st_valid, 0);
        chk("R1 flush", flush, 0);
        chk("R1 look_hit", look_hit, 0);

        // Sweep all completion orders of a full queue
        p = 0;
        for (int a = 0; a < D; a++)
        for (int b = 0; b < D; b++)
        for (int c = 0; c < D; c++)
        for (int d = 0; d < D; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                int ord [4];
                int base;
                ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
                base = mt;
                for (int k = 0; k < D; k++) begin
                    put(((p + k) % 5) == 0, (p + k) % 8, 16'h200 + p * 8 + k);
                    cycle();
                end
                put(0, 7, 16'hfff);
                cycle();
                chk("R3 full queue ignores alloc", alloc_idx, base);
                for (int j = 0; j < D; j++) begin
                    fin((base + ord[j]) % D, p * 64 + j * 7 + 1, 16'h8000 + p * 4 + j, 0);
                    cycle();
                    if (j == 0 && ord[0] != 0)
                        chk("R4 younger finished waits", {31'b0, rf_we | st_valid}, 0);
                end
                repeat (D) cycle();
                p++;
            end
        end

        // R9: allocation and retirement in one cycle
        t = mt;
        put(0, 1, 16'h400); cycle();
        fin(t, 16'h0a0a, 0, 0); cycle();
        put(0, 2, 16'h401);
        #1;
        chk("R9 head retires in pair cycle", rf_we, 1);
        chk("R9 alloc accepted in pair cycle", alloc_ready, 1);
        cycle();
        chk("R9 tail advanced by one", alloc_idx, (t + 2) % D);
        fin((t + 1) % D, 16'h0b0b, 0, 0); cycle();
        repeat (2) cycle();

        // R10: completion to an idle slot
        t = mt;
        fin(t, 16'h1234, 0, 0); cycle();
        put(0, 5, 16'h500); cycle();
        look_reg = 3'd5;
        #1;
        chk("R10 idle completion ignored hit", look_hit, 1);
        chk("R10 idle completion ignored ready", look_ready, 0);
        fin(t, 16'h2222, 0, 0); cycle();
        repeat (2) cycle();

        // R7: exception behind a normal head
        t = mt;
        put(0, 1, 16'h300); cycle();
        put(0, 2, 16'h301); cycle();
        put(0, 3, 16'h302); cycle();
        fin((t + 1) % D, 16'h0eee, 0, 1); cycle();
        fin(t, 16'h0111, 0, 0); cycle();
        cycle();
        chk("R7 flush raised", flush, 1);
        chk("R7 flush_pc", flush_pc, 16'h301);
        put(0, 6, 16'h3ff);
        fin((t + 2) % D, 16'h0333, 0, 0);
        cycle();
        chk("R7 tail reset after flush", alloc_idx, 0);
        chk("R7 ready after flush", alloc_ready, 1);
        look_reg = 3'd3;
        #1;
        chk("R7 no survivor after flush", look_hit, 0);

        // Pseudo-random mixed traffic
        r = 16'hace1;
        for (int i = 0; i < 3000; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            alloc_valid    = r[0] | r[1];
            alloc_is_store = r[2] & r[3];
            alloc_dest     = r[6:4];
            alloc_pc       = r;
            cmp_valid      = r[7];
            cmp_idx        = r[9:8];
            cmp_value      = r ^ 16'h5a5a;
            cmp_st_addr    = r + 16'd3;
            cmp_exc        = (r[15:12] == 4'd0);
            cycle();
        end

        summary();
        $finish;
    end

endmodule